// File: doc/BRIEF.md
# Carry completion sensing adder

This block adds two unsigned operands and a carry-in. It does not wait a fixed worst-case carry delay. Each bit position holds a registered pair of rails that encodes its carry-out. The pair (0,0) means the carry is not known yet. The pair (1,0) means a carry of one. The pair (0,1) means a carry of zero. A position whose two operand bits are equal knows its carry straight away. A position whose operand bits differ copies the rail pair of the position below it. Known carries therefore move one position toward the most significant bit on each clock.

When every position holds a known carry, the block registers the sum and the carry-out and raises `done`. The add takes as many cycles as its longest propagate chain, not as many as the operand width. For random operands this is only a few cycles.

A user pulses `start` with the operands while the block is idle or finished. The user then waits for `done`. The result stays on the outputs until the next accepted start.

Top module: `carry_sense_adder`

## Requirements
- R1: After reset, `sum`, `carry_out`, `busy` and `done` are all 0.
- R2: A `start` seen while `busy` is 0 is accepted at that clock edge. From the next cycle on, `busy` is 1 and `done` is 0. This also holds when `done` was 1 at that edge.
- R3: When `done` is 1, `{carry_out, sum}` equals op_a + op_b + carry_in, using the values captured at the accepting edge.
- R4: Each position has a resolution time. A position with equal operand bits resolves in 1 cycle. A position with differing operand bits resolves one cycle after the position below it. The carry-in counts as resolved at time 0. `done` rises exactly L clock edges after the accepting edge, where L is the largest resolution time over all positions. A position's rail pair does not change once its carry is known, until the next start.
- R5: When every position has differing operand bits, the add takes exactly WIDTH cycles. No add takes longer than WIDTH cycles.
- R6: No position ever holds both rails at 1.
- R7: A `start` pulse while `busy` is 1 has no effect. The operands and result of the add in progress are kept, and so is its completion cycle.
- R8: Once `done` is 1, it stays 1 and `sum` and `carry_out` stay unchanged until the next accepted start.
- R9: `busy` and `done` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an add; accepted only while not busy |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum, valid while done |
| carry_out | output | 1 | Registered carry out of the top bit |
| busy | output | 1 | Add in progress |
| done | output | 1 | Result valid and held |

## Verification
The bench uses a 5-bit instance and sweeps every pair of operands with both carry-in values. For each add it compares the sum, the carry-out and the exact completion cycle with values worked out in the bench. The exact cycle count is what separates correct one-position-per-clock movement from a design that resolves too early or too late. Operand pairs in which every bit differs exercise the width-long worst case. Pairs with no differing bits show completion in one cycle. A start pulse is injected in the middle of a long add to show that it is ignored. An idle hold after completion shows that the result and `done` stay put.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Two-rail carry code: c=1 carry known one, n=1 carry known zero.
  typedef struct packed {
    logic c;
    logic n;
  } rail_t;

  localparam rail_t RAIL_UNKNOWN = '{c: 1'b0, n: 1'b0};

  function automatic rail_t rail_of_bit(input logic v);
    rail_of_bit = '{c: v, n: ~v};
  endfunction

  function automatic logic rail_known(input rail_t r);
    rail_known = r.c | r.n;
  endfunction
endpackage

// File: rtl/cs_rail_cell.sv
module cs_rail_cell
  import cs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  run,
  input  logic  bit_a,
  input  logic  bit_b,
  input  rail_t lower,
  output rail_t cur,
  output rail_t nxt
);
  // Equal operand bits settle the carry locally; otherwise pass the lower rails up.
  always_comb begin
    if (bit_a == bit_b) nxt = rail_of_bit(bit_a);
    else                nxt = lower;
  end

  always_ff @(posedge clk) begin
    if (rst)        cur <= RAIL_UNKNOWN;
    else if (clear) cur <= RAIL_UNKNOWN;
    else if (run)   cur <= nxt;
  end

  // R6
  both_rails_chk: assert property (@(posedge clk) disable iff (rst)
    !(cur.c && cur.n));

  // R4
  resolved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clear && rail_known(cur)) |=> $stable(cur));
endmodule

// File: rtl/cs_resolve_detect.sv
module cs_resolve_detect #(
  parameter int WIDTH = 15
) (
  input  logic [WIDTH-1:0] c_v,
  input  logic [WIDTH-1:0] n_v,
  output logic             all_known
);
  logic [WIDTH-1:0] known;

  for (genvar i = 0; i < WIDTH; i++) begin : g_known
    assign known[i] = c_v[i] | n_v[i];
  end

  assign all_known = &known;
endmodule

// File: rtl/cs_sum_unit.sv
module cs_sum_unit #(
  parameter int WIDTH = 15
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [WIDTH-1:0] c_v,
  output logic [WIDTH-1:0] s
);
  logic [WIDTH-1:0] carry_into;

  if (WIDTH == 1) begin : g_one
    assign carry_into = cin;
  end else begin : g_many
    assign carry_into = {c_v[WIDTH-2:0], cin};
  end

  assign s = a ^ b ^ carry_into;
endmodule

// File: rtl/carry_sense_adder.sv
module carry_sense_adder
  import cs_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = $clog2(WIDTH + 2);

  logic [WIDTH-1:0] a_q, b_q;
  logic             cin_q;
  logic             busy_q, done_q;
  logic [WIDTH-1:0] sum_q;
  logic             cout_q;
  logic             accept;
  logic             all_known;

  rail_t [WIDTH-1:0] rail_cur, rail_nxt, rail_low;
  logic  [WIDTH-1:0] c_nxt, n_nxt;
  logic  [WIDTH-1:0] sum_nxt;

  assign accept = start && !busy_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    if (i == 0) begin : g_lsb
      assign rail_low[i] = rail_of_bit(cin_q);
    end else begin : g_up
      assign rail_low[i] = rail_cur[i-1];
    end

    cs_rail_cell i_cell (
      .clk   (clk),
      .rst   (rst),
      .clear (accept),
      .run   (busy_q),
      .bit_a (a_q[i]),
      .bit_b (b_q[i]),
      .lower (rail_low[i]),
      .cur   (rail_cur[i]),
      .nxt   (rail_nxt[i])
    );

    assign c_nxt[i] = rail_nxt[i].c;
    assign n_nxt[i] = rail_nxt[i].n;
  end

  cs_resolve_detect #(.WIDTH(WIDTH)) i_detect (
    .c_v       (c_nxt),
    .n_v       (n_nxt),
    .all_known (all_known)
  );

  cs_sum_unit #(.WIDTH(WIDTH)) i_sum (
    .a   (a_q),
    .b   (b_q),
    .cin (cin_q),
    .c_v (c_nxt),
    .s   (sum_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      cin_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (accept) begin
      a_q    <= op_a;
      b_q    <= op_b;
      cin_q  <= carry_in;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && all_known) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      sum_q  <= sum_nxt;
      cout_q <= c_nxt[WIDTH-1];
    end
  end

  assign sum       = sum_q;
  assign carry_out = cout_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // Cycle count of the current add, used only by the latency bound check.
  logic [CNT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst || accept) lat_cnt <= '0;
    else if (busy_q)   lat_cnt <= lat_cnt + 1'b1;
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_q && !done_q));

  // R3
  result_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ({cout_q, sum_q} ==
      ({1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q})));

  // R5
  latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(lat_cnt) < WIDTH));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(sum_q) && $stable(cout_q)));

  // R9
  state_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(a_q) && $stable(b_q) && $stable(cin_q)));
endmodule

// File: tb/test_carry_sense_adder.sv
module test_carry_sense_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] op_a, op_b;
  logic         carry_in;
  logic [W-1:0] sum;
  logic         carry_out, busy, done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_sense_adder #(.WIDTH(W)) i_carry_sense_adder (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum(sum), .carry_out(carry_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [W-1:0] a, input logic [W-1:0] b);
    int t_prev = 0;
    int t;
    int worst = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i] == b[i]) t = 1;
      else              t = t_prev + 1;
      if (t > worst) worst = t;
      t_prev = t;
    end
    return worst;
  endfunction

  // Launch an add; return measured cycles from the accepting edge to done.
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input logic inject, output int cyc);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; carry_in = ci;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b; carry_in = ~ci;
    chk("R2 busy after accept", busy, 1);
    chk("R2 done low after accept", done, 0);
    cyc = 0;
    while (!done && cyc <= W + 3) begin
      if (inject && cyc == 1) start = 1'b1;
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
      if (!done) chk("R9 not busy and done", busy && done, 0);
    end
  endtask

  task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic ci, input int cyc, input string tag);
    logic [W:0] total;
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    chk({tag, " R3 sum"}, sum, total[W-1:0]);
    chk({tag, " R3 carry_out"}, carry_out, total[W]);
    chk({tag, " R4 latency"}, cyc, exp_latency(a, b));
    chk({tag, " R9 busy low at done"}, busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] hold_sum;
    rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 sum", sum, 0);
    chk("R1 carry_out", carry_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);

    // R3 R4 exhaustive sweep
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          run_add(W'(a), W'(b), 1'(ci), 1'b0, cyc);
          check_result(W'(a), W'(b), 1'(ci), cyc, "sweep");
        end
      end
    end

    // R5 worst case: every bit differs
    run_add(5'b10101, 5'b01010, 1'b1, 1'b0, cyc);
    chk("R5 worst case cycles", cyc, W);
    check_result(5'b10101, 5'b01010, 1'b1, cyc, "R5");
    run_add(5'b11111, 5'b00000, 1'b0, 1'b0, cyc);
    chk("R5 worst case cin0 cycles", cyc, W);
    chk("R5 worst case sum", sum, 5'b11111);

    // R4 no propagate positions: one cycle
    run_add(5'b10110, 5'b10110, 1'b1, 1'b0, cyc);
    chk("R4 single cycle", cyc, 1);

    // R7 start during busy is ignored
    run_add(5'b01111, 5'b10000, 1'b1, 1'b1, cyc);
    chk("R7 cycles unchanged", cyc, W);
    chk("R7 sum of original add", sum, 5'b00000);
    chk("R7 carry of original add", carry_out, 1);

    // R8 hold while idle
    hold_sum = sum;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 sum held", sum, hold_sum);
    chk("R8 carry held", carry_out, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule